// File: doc/BRIEF.md
# Masked Linear Share Unit

This unit performs the linear operations of a share-protected datapath on words carried as three 32-bit Boolean shares. The true value of such a word is the XOR of its three shares. The unit can XOR two shared words. It can also XOR a shared word with a plain 32-bit public value. Finally, it can rotate a shared word left or right by a public offset. It never combines the shares of a word with each other, so no intermediate signal ever carries the secret value in the clear.

Each operation is linear, so it can be applied to every share on its own. A public XOR operand is folded into the third share only. A rotation applies the same public amount to every share. The offset comes from an 8-bit unmasked source, and only its value modulo 32 takes effect. A request is accepted in one cycle. The result is registered and is presented one cycle later together with a valid strobe.

The control is a two-state machine. In state ST_IDLE no fresh result is presented. In state ST_DONE the result of the request from the previous cycle is presented. The transition "accept" goes from either state to ST_DONE when `req_valid` is high. The transition "drain" goes from either state to ST_IDLE when `req_valid` is low.

Top module: `masked_linear_unit`

## Requirements
- R1: While reset is active and in the first cycle after it, `res_valid` is 0 and `res` is all zeros.
- R2: `res_valid` is 1 in exactly the cycle after a cycle in which `req_valid` was 1 at the clock edge, and 0 otherwise. Back-to-back requests give back-to-back results.
- R3: Share k of a word occupies bits [32k+31:32k] for k = 0, 1, 2. The third share is bits [95:64]. With `req_op` = 2'b00, the result is the share-wise XOR of `opa` and `opb`.
- R4: With `req_op` = 2'b01, shares 0 and 1 of the result equal those of `opa`. Share 2 equals share 2 of `opa` XOR `pub_b`. `opb` has no effect.
- R5: With `req_op` = 2'b10, every share of `opa` is rotated left by `rot_amt` modulo 32.
- R6: Bits of `rot_amt` above bit 4 have no effect. An offset of 37 acts like an offset of 5, and 32 acts like 0.
- R7: With `req_op` = 2'b11, every share is rotated right by n = `rot_amt` modulo 32. This is done as a left rotation by (32 - n) modulo 32, so n = 0 leaves the word unchanged.
- R8: In a cycle with `req_valid` low, `res` keeps its previous value, whatever the other inputs are.
- R9: The XOR of the three result shares equals the same operation applied to the XOR of the input shares.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one operation per cycle |
| req_op | input | 2 | Operation select (00 masked XOR, 01 public XOR, 10 rotate left, 11 rotate right) |
| opa | input | 96 | First shared operand |
| opb | input | 96 | Second shared operand for op 00 |
| pub_b | input | 32 | Public XOR operand for op 01 |
| rot_amt | input | 8 | Public rotation offset |
| res_valid | output | 1 | Result strobe, one cycle after a request |
| res | output | 96 | Registered shared result |

## Verification
Corrupted control state shows up at `res_valid` in the very next cycle. The strobe goes missing, appears without a request, or is stretched. A wrong update enable shows as `res` changing during a cycle with no request, or failing to change on an accepted one. Both are visible one edge after the cause. Datapath faults in the share routing are visible on the first affected request. Examples are a public operand folded into the wrong share, a rotation applied to only some shares, or offset bits above bit 4 leaking into the amount. Per-share checks catch these even when the XOR of the shares happens to stay correct.

// File: rtl/mlu_pkg.sv
package mlu_pkg;

    localparam int unsigned DEF_SHARE_W = 32;
    localparam int unsigned DEF_NSHARE  = 3;
    localparam int unsigned DEF_OFS_W   = 8;

    typedef enum logic [1:0] {
        OP_XOR_SHARED = 2'b00,
        OP_XOR_PUBLIC = 2'b01,
        OP_ROT_LEFT   = 2'b10,
        OP_ROT_RIGHT  = 2'b11
    } lin_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } ctl_state_e;

endpackage

// File: rtl/mlu_ctrl.sv
module mlu_ctrl
    import mlu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    output logic load_en,
    output logic res_valid
);

    ctl_state_e state_q;
    ctl_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_DONE : ST_IDLE;
            ST_DONE: state_d = req_valid ? ST_DONE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load_en   = req_valid;
        res_valid = (state_q == ST_DONE);
    end

    // R2
    valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);

    // R2
    valid_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid);

endmodule

// File: rtl/mlu_amt_norm.sv
module mlu_amt_norm
    import mlu_pkg::*;
#(
    parameter int unsigned SHARE_W = DEF_SHARE_W,
    parameter int unsigned OFS_W   = DEF_OFS_W
) (
    input  logic [OFS_W-1:0] rot_amt,
    input  logic             dir_right,
    output logic [OFS_W-1:0] amt_left
);

    localparam logic [OFS_W-1:0] WIDTH_C = OFS_W'(SHARE_W);

    logic [OFS_W-1:0] amt_mod;

    always_comb begin
        amt_mod = rot_amt % WIDTH_C;
        if (dir_right) begin
            amt_left = (WIDTH_C - amt_mod) % WIDTH_C;
        end else begin
            amt_left = amt_mod;
        end
    end

    // R6
    amt_in_range_chk: assert final (amt_left < WIDTH_C);

endmodule

// File: rtl/mlu_share_rot.sv
module mlu_share_rot
    import mlu_pkg::*;
#(
    parameter int unsigned SHARE_W = DEF_SHARE_W,
    parameter int unsigned OFS_W   = DEF_OFS_W
) (
    input  logic [SHARE_W-1:0] din,
    input  logic [OFS_W-1:0]   amt,
    output logic [SHARE_W-1:0] dout
);

    localparam int unsigned DBL_W = 2 * SHARE_W;

    logic [DBL_W-1:0] doubled;

    always_comb begin
        doubled = {din, din} << amt;
        dout    = doubled[DBL_W-1:SHARE_W];
    end

endmodule

// File: rtl/masked_linear_unit.sv
module masked_linear_unit
    import mlu_pkg::*;
#(
    parameter int unsigned SHARE_W = DEF_SHARE_W,
    parameter int unsigned NSHARE  = DEF_NSHARE,
    parameter int unsigned OFS_W   = DEF_OFS_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [1:0]                  req_op,
    input  logic [SHARE_W*NSHARE-1:0]   opa,
    input  logic [SHARE_W*NSHARE-1:0]   opb,
    input  logic [SHARE_W-1:0]          pub_b,
    input  logic [OFS_W-1:0]            rot_amt,
    output logic                        res_valid,
    output logic [SHARE_W*NSHARE-1:0]   res
);

    localparam int unsigned WORD_W = SHARE_W * NSHARE;
    localparam int unsigned LAST   = NSHARE - 1;

    lin_op_e             op;
    logic                load_en;
    logic [OFS_W-1:0]    amt_left;
    logic [WORD_W-1:0]   rot_word;
    logic [WORD_W-1:0]   next_word;
    logic [WORD_W-1:0]   res_q;

    assign op = lin_op_e'(req_op);

    mlu_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .load_en   (load_en),
        .res_valid (res_valid)
    );

    mlu_amt_norm #(
        .SHARE_W (SHARE_W),
        .OFS_W   (OFS_W)
    ) u_amt (
        .rot_amt   (rot_amt),
        .dir_right (op == OP_ROT_RIGHT),
        .amt_left  (amt_left)
    );

    for (genvar k = 0; k < NSHARE; k++) begin : g_share
        mlu_share_rot #(
            .SHARE_W (SHARE_W),
            .OFS_W   (OFS_W)
        ) u_rot (
            .din  (opa[k*SHARE_W +: SHARE_W]),
            .amt  (amt_left),
            .dout (rot_word[k*SHARE_W +: SHARE_W])
        );
    end

    always_comb begin
        next_word = opa;
        unique case (op)
            OP_XOR_SHARED: next_word = opa ^ opb;
            OP_XOR_PUBLIC: next_word[LAST*SHARE_W +: SHARE_W] =
                               opa[LAST*SHARE_W +: SHARE_W] ^ pub_b;
            OP_ROT_LEFT,
            OP_ROT_RIGHT:  next_word = rot_word;
            default:       next_word = opa;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else if (load_en) begin
            res_q <= next_word;
        end
    end

    assign res = res_q;

    function automatic logic [SHARE_W-1:0] fold(input logic [WORD_W-1:0] w);
        logic [SHARE_W-1:0] acc;
        acc = '0;
        for (int i = 0; i < NSHARE; i++) acc ^= w[i*SHARE_W +: SHARE_W];
        return acc;
    endfunction

    function automatic logic [SHARE_W-1:0] ref_rol(input logic [SHARE_W-1:0] x,
                                                    input int unsigned n);
        int unsigned m;
        m = n % SHARE_W;
        if (m == 0) return x;
        return (x << m) | (x >> (SHARE_W - m));
    endfunction

    // R8
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(res));

    // R4
    public_xor_low_shares_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b01) |=>
            res[LAST*SHARE_W-1:0] == $past(opa[LAST*SHARE_W-1:0]));

    // R9
    shared_xor_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b00) |=>
            fold(res) == (fold($past(opa)) ^ fold($past(opb))));

    // R9
    public_xor_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b01) |=>
            fold(res) == (fold($past(opa)) ^ $past(pub_b)));

    // R5
    rotl_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b10) |=>
            fold(res) == ref_rol(fold($past(opa)), int'($past(rot_amt))));

    // R7
    rotr_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b11) |=>
            ref_rol(fold(res), int'($past(rot_amt))) == fold($past(opa)));

endmodule

// File: tb/masked_linear_unit_test.sv
module masked_linear_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b00;
    logic [95:0] opa = '0;
    logic [95:0] opb = '0;
    logic [31:0] pub_b = '0;
    logic [7:0]  rot_amt = '0;
    logic        res_valid;
    logic [95:0] res;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    masked_linear_unit uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .opa(opa), .opb(opb), .pub_b(pub_b), .rot_amt(rot_amt),
        .res_valid(res_valid), .res(res)
    );

    function automatic logic [31:0] rol32(input logic [31:0] x, input int n);
        int m = n % 32;
        if (m == 0) return x;
        return (x << m) | (x >> (32 - m));
    endfunction

    function automatic logic [95:0] rol_all(input logic [95:0] w, input int n);
        return {rol32(w[95:64], n), rol32(w[63:32], n), rol32(w[31:0], n)};
    endfunction

    function automatic logic [31:0] fold(input logic [95:0] w);
        return w[95:64] ^ w[63:32] ^ w[31:0];
    endfunction

    task automatic check(input string req, input logic [95:0] got, input logic [95:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [95:0] a, input logic [95:0] b,
                         input logic [31:0] p, input logic [7:0] n);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; opa = a; opb = b; pub_b = p; rot_amt = n;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 valid in reset", {95'd0, res_valid}, 96'd0);
        check("R1 res in reset", res, 96'd0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 valid after reset", {95'd0, res_valid}, 96'd0);
        check("R1 res after reset", res, 96'd0);
    endtask

    task automatic t_shared_xor();
        logic [95:0] a = 96'h0123_4567_89ab_cdef_fedc_ba98;
        logic [95:0] b = 96'hffff_0000_1234_5678_0f0f_f0f0;
        issue(2'b00, a, b, 32'hdead_beef, 8'd3);
        check("R3 shared xor", res, a ^ b);
        check("R2 valid after req", {95'd0, res_valid}, 96'd1);
        check("R9 shared xor value", {64'd0, fold(res)}, {64'd0, fold(a) ^ fold(b)});
    endtask

    task automatic t_public_xor();
        logic [95:0] a = 96'h1111_2222_3333_4444_5555_6666;
        issue(2'b01, a, 96'hffff_ffff_ffff_ffff_ffff_ffff, 32'hcafe_f00d, 8'd0);
        check("R4 public xor", res, {a[95:64] ^ 32'hcafe_f00d, a[63:0]});
        check("R9 public xor value", {64'd0, fold(res)}, {64'd0, fold(a) ^ 32'hcafe_f00d});
    endtask

    task automatic t_rotl();
        logic [95:0] a = 96'h8000_0001_1234_5678_f000_000f;
        issue(2'b10, a, '0, '0, 8'd7);
        check("R5 rotl 7", res, rol_all(a, 7));
        issue(2'b10, a, '0, '0, 8'd0);
        check("R5 rotl 0", res, a);
        issue(2'b10, a, '0, '0, 8'd37);
        check("R6 offset 37", res, rol_all(a, 5));
        issue(2'b10, a, '0, '0, 8'd32);
        check("R6 offset 32", res, a);
        issue(2'b10, a, '0, '0, 8'd255);
        check("R6 offset 255", res, rol_all(a, 31));
    endtask

    task automatic t_rotr();
        logic [95:0] a = 96'h0000_00ff_abcd_ef01_1357_9bdf;
        issue(2'b11, a, '0, '0, 8'd8);
        check("R7 rotr 8", res, rol_all(a, 24));
        issue(2'b11, a, '0, '0, 8'd0);
        check("R7 rotr 0", res, a);
        issue(2'b11, a, '0, '0, 8'd33);
        check("R7 rotr 33", res, rol_all(a, 31));
    endtask

    task automatic t_hold();
        logic [95:0] a = 96'h0bad_0bad_cafe_cafe_5a5a_a5a5;
        logic [95:0] snap;
        issue(2'b00, a, '0, '0, '0);
        snap = res;
        @(negedge clk);
        req_op = 2'b01; opa = ~a; pub_b = 32'hffff_ffff;
        @(posedge clk); #1;
        check("R8 res held", res, snap);
        check("R2 valid low when idle", {95'd0, res_valid}, 96'd0);
    endtask

    task automatic t_back_to_back();
        logic [95:0] a = 96'h0102_0304_0506_0708_090a_0b0c;
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'b10; opa = a; rot_amt = 8'd4;
        @(posedge clk); #1;
        check("R2 first of pair valid", {95'd0, res_valid}, 96'd1);
        check("R5 first of pair", res, rol_all(a, 4));
        @(negedge clk);
        req_op = 2'b01; pub_b = 32'h0000_ffff;
        @(posedge clk); #1;
        req_valid = 1'b0;
        check("R2 second of pair valid", {95'd0, res_valid}, 96'd1);
        check("R4 second of pair", res, {a[95:64] ^ 32'h0000_ffff, a[63:0]});
        @(posedge clk); #1;
        check("R2 valid drops", {95'd0, res_valid}, 96'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        t_shared_xor();
        t_public_xor();
        t_rotl();
        t_rotr();
        t_hold();
        t_back_to_back();
        repeat (2) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule